// File: doc/BRIEF.md
# One-time-programmable fuse array controller

This block sits between a register bus and an array of one-time-programmable 32-bit fuse rows. Software loads a row index and, for programming, a word of bits to blow. It then writes a command code into the control register. The controller leaves its idle state and runs a read, a program pulse or a sense scan, then returns to idle. Software learns that a command has finished by polling a 5-bit state field. The fuse array is a behavioural model inside the block. Its cells start at zero after reset, and a program operation can only turn bits on.

Programming is guarded in three independent ways: a write-access register, a programming-disable register and the power-down bit of the control register. A guarded program still runs its full pulse, but the array does not change. A sense operation copies every row into a shadow bank that software can read through a separate window. When the last row has been copied, the controller raises a sense-done flag. The program pulse lasts a number of clock cycles held in a register. Its reset value is the clock frequency times five microseconds, rounded up.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the register map reads as follows. Control (offset 0x00) reads 0x0404_0000: state code 4 at bits [20:16], power-down at bit 26 set, and the command field, the mirror-disable bit 28 and the sense-done bit 30 clear. Write-access (0x30) reads 1. Programming-disable (0x2C) reads 0. Read data (0x08) reads 0. Pulse width (0x1C) reads ceil(CLK_KHZ*5/1000), which is 250 at 50 MHz.
- R2: A control write whose bits [1:0] equal 1 (read) holds the state field at 9 for RD_LAT (2) cycles. The controller then loads the read-data register with the addressed row and shows state 4 again.
- R3: A control write with command 2 (program) ORs the write-data register (0x0C) into the addressed row. A bit that is already 1 stays 1, and a 0 in the write data never clears a bit.
- R4: A program holds the state field at 10 for exactly the number of cycles in the pulse-width register. A width of 0 counts as 1 cycle.
- R5: A program leaves the array unchanged when write-access holds a nonzero value, when programming-disable holds a nonzero value, or when power-down is set. It still takes its full pulse and returns to state 4.
- R6: A sense starts on command 3 or on a write with bit 0 set to the sense-start register (0x20). It clears sense-done and holds state 11 for ROWS cycles, copying one row per cycle into the shadow bank. It then sets sense-done (bit 30). The shadow keeps its old contents until a sense runs.
- R7: A control write that arrives while the state field is not 4 is ignored entirely: the command, power-down and mirror-disable fields keep their values. While idle, such a write stores bits [1:0], 26 and 28.
- R8: Shadow row n reads at offset 0x100 + 4*n. The row index is the low log2(ROWS) bits of the address register (0x04), and the higher address bits are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
The hardest case to reach is a control write that lands while a program pulse is still running. To produce it, the stimulus drives a second control write, carrying power-down and a read command, one cycle into a multi-cycle pulse. It then checks three things: the running program still blows its bits, power-down stays clear, and no read follows. The guards are each exercised alone, with the other two open, so that a blocked program proves which guard stopped it. The shadow bank is read both before and after a sense, so that a stale copy can be told apart from a fresh one.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
    localparam int unsigned DW = 32;
    localparam int unsigned AW = 12;

    localparam logic [AW-1:0] OFF_CTRL  = 12'h000;
    localparam logic [AW-1:0] OFF_ROW   = 12'h004;
    localparam logic [AW-1:0] OFF_RDAT  = 12'h008;
    localparam logic [AW-1:0] OFF_WDAT  = 12'h00C;
    localparam logic [AW-1:0] OFF_PULSE = 12'h01C;
    localparam logic [AW-1:0] OFF_SENSE = 12'h020;
    localparam logic [AW-1:0] OFF_PDIS  = 12'h02C;
    localparam logic [AW-1:0] OFF_WACC  = 12'h030;
    localparam logic [3:0]    SHADOW_PAGE = 4'h1;

    localparam int unsigned BIT_PD   = 26;
    localparam int unsigned BIT_MDIS = 28;
    localparam int unsigned BIT_DONE = 30;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_PROG  = 2'd2,
        OP_SENSE = 2'd3
    } fuse_op_e;

    typedef enum logic [4:0] {
        ST_IDLE  = 5'd4,
        ST_READ  = 5'd9,
        ST_PROG  = 5'd10,
        ST_SENSE = 5'd11
    } fuse_state_e;
endpackage

// File: rtl/fuse_pulse_timer.sv
module fuse_pulse_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign expire = t_q.run && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = (limit == '0) ? '0 : limit - 1'b1;
        end else if (expire) begin
            t_d.run = 1'b0;
        end else if (t_q.run) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/fuse_array_model.sv
module fuse_array_model #(
    parameter int unsigned ROWS = 16,
    parameter int unsigned DW   = 32,
    localparam int unsigned RIW = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_en,
    input  logic [RIW-1:0]     prog_row,
    input  logic [DW-1:0]      prog_bits,
    input  logic [RIW-1:0]     rd_row,
    output logic [DW-1:0]      rd_bits,
    input  logic               scan_en,
    input  logic [RIW-1:0]     scan_row,
    input  logic [RIW-1:0]     shw_row,
    output logic [DW-1:0]      shw_bits,
    output logic [ROWS*DW-1:0] rows_flat
);
    logic [DW-1:0] cell_d [ROWS];
    logic [DW-1:0] cell_q [ROWS];
    logic [DW-1:0] shad_d [ROWS];
    logic [DW-1:0] shad_q [ROWS];

    assign rd_bits  = cell_q[rd_row];
    assign shw_bits = shad_q[shw_row];

    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign rows_flat[g*DW +: DW] = cell_q[g];
    end

    always_comb begin
        for (int i = 0; i < ROWS; i++) begin
            cell_d[i] = cell_q[i];
            shad_d[i] = shad_q[i];
        end
        if (prog_en) cell_d[prog_row] = cell_q[prog_row] | prog_bits;
        if (scan_en) shad_d[scan_row] = cell_q[scan_row];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROWS; i++) begin
            if (!rst_n) begin
                cell_q[i] <= '0;
                shad_q[i] <= '0;
            end else begin
                cell_q[i] <= cell_d[i];
                shad_q[i] <= shad_d[i];
            end
        end
    end
endmodule

// File: rtl/fuse_cmd_fsm.sv
module fuse_cmd_fsm
    import fuse_ctrl_pkg::*;
#(
    parameter int unsigned ROWS   = 16,
    parameter int unsigned PW_W   = 16,
    parameter int unsigned RD_LAT = 2,
    localparam int unsigned RIW   = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_go,
    input  fuse_op_e        cmd_op,
    input  logic            sense_go,
    input  logic [PW_W-1:0] pulse_len,
    output fuse_state_e     state,
    output logic            rd_load,
    output logic            prog_fire,
    output logic            scan_en,
    output logic [RIW-1:0]  scan_row,
    output logic            sense_done
);
    typedef struct packed {
        fuse_state_e    st;
        logic [RIW-1:0] row;
        logic           done;
    } fsm_t;

    fsm_t f_d, f_q;
    logic            tmr_start;
    logic [PW_W-1:0] tmr_limit;
    logic            tmr_expire;

    fuse_pulse_timer #(.CW(PW_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .limit  (tmr_limit),
        .expire (tmr_expire)
    );

    assign state      = f_q.st;
    assign scan_row   = f_q.row;
    assign sense_done = f_q.done;

    always_comb begin
        f_d       = f_q;
        tmr_start = 1'b0;
        tmr_limit = '0;
        rd_load   = 1'b0;
        prog_fire = 1'b0;
        scan_en   = 1'b0;
        unique case (f_q.st)
            ST_IDLE: begin
                if (cmd_go && cmd_op == OP_READ) begin
                    f_d.st    = ST_READ;
                    tmr_start = 1'b1;
                    tmr_limit = PW_W'(RD_LAT);
                end else if (cmd_go && cmd_op == OP_PROG) begin
                    f_d.st    = ST_PROG;
                    tmr_start = 1'b1;
                    tmr_limit = pulse_len;
                end else if ((cmd_go && cmd_op == OP_SENSE) || sense_go) begin
                    f_d.st   = ST_SENSE;
                    f_d.row  = '0;
                    f_d.done = 1'b0;
                end
            end
            ST_READ: begin
                if (tmr_expire) begin
                    rd_load = 1'b1;
                    f_d.st  = ST_IDLE;
                end
            end
            ST_PROG: begin
                if (tmr_expire) begin
                    prog_fire = 1'b1;
                    f_d.st    = ST_IDLE;
                end
            end
            ST_SENSE: begin
                scan_en = 1'b1;
                if (f_q.row == RIW'(ROWS - 1)) begin
                    f_d.done = 1'b1;
                    f_d.st   = ST_IDLE;
                end else begin
                    f_d.row = f_q.row + 1'b1;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.st   <= ST_IDLE;
            f_q.row  <= '0;
            f_q.done <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
    import fuse_ctrl_pkg::*;
#(
    parameter int unsigned ROWS     = 16,
    parameter int unsigned CLK_KHZ  = 50000,
    parameter int unsigned PULSE_US = 5,
    parameter int unsigned RD_LAT   = 2,
    parameter int unsigned PW_W     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [11:0]   reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata
);
    localparam int unsigned RIW      = $clog2(ROWS);
    localparam int unsigned PW_RESET = (CLK_KHZ * PULSE_US + 999) / 1000;

    typedef struct packed {
        logic [RIW-1:0]  row;
        logic [DW-1:0]   wdat;
        logic [DW-1:0]   rdat;
        logic [PW_W-1:0] pulse;
        logic [DW-1:0]   pdis;
        logic [DW-1:0]   wacc;
        logic [1:0]      cmd;
        logic            pd;
        logic            mdis;
    } regs_t;

    regs_t r_d, r_q;

    fuse_state_e       state;
    logic              rd_load, prog_fire, scan_en, sense_done;
    logic [RIW-1:0]    scan_row;
    logic [DW-1:0]     rd_bits, shw_bits;
    logic [ROWS*DW-1:0] rows_flat;
    logic              ctrl_wr, cmd_go, sense_go, prog_ok;

    assign ctrl_wr  = reg_wr_en && (reg_addr == OFF_CTRL) && (state == ST_IDLE);
    assign cmd_go   = ctrl_wr && (reg_wdata[1:0] != 2'd0);
    assign sense_go = reg_wr_en && (reg_addr == OFF_SENSE) && reg_wdata[0];
    assign prog_ok  = (r_q.wacc == '0) && (r_q.pdis == '0) && !r_q.pd;

    fuse_cmd_fsm #(.ROWS(ROWS), .PW_W(PW_W), .RD_LAT(RD_LAT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (cmd_go),
        .cmd_op     (fuse_op_e'(reg_wdata[1:0])),
        .sense_go   (sense_go),
        .pulse_len  (r_q.pulse),
        .state      (state),
        .rd_load    (rd_load),
        .prog_fire  (prog_fire),
        .scan_en    (scan_en),
        .scan_row   (scan_row),
        .sense_done (sense_done)
    );

    fuse_array_model #(.ROWS(ROWS), .DW(DW)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_fire && prog_ok),
        .prog_row  (r_q.row),
        .prog_bits (r_q.wdat),
        .rd_row    (r_q.row),
        .rd_bits   (rd_bits),
        .scan_en   (scan_en),
        .scan_row  (scan_row),
        .shw_row   (reg_addr[RIW+1:2]),
        .shw_bits  (shw_bits),
        .rows_flat (rows_flat)
    );

    always_comb begin
        r_d = r_q;
        if (ctrl_wr) begin
            r_d.cmd  = reg_wdata[1:0];
            r_d.pd   = reg_wdata[BIT_PD];
            r_d.mdis = reg_wdata[BIT_MDIS];
        end
        if (reg_wr_en) begin
            unique case (reg_addr)
                OFF_ROW:   r_d.row   = reg_wdata[RIW-1:0];
                OFF_WDAT:  r_d.wdat  = reg_wdata;
                OFF_PULSE: r_d.pulse = reg_wdata[PW_W-1:0];
                OFF_PDIS:  r_d.pdis  = reg_wdata;
                OFF_WACC:  r_d.wacc  = reg_wdata;
                default: ;
            endcase
        end
        if (rd_load) r_d.rdat = rd_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.pulse <= PW_W'(PW_RESET);
            r_q.wacc  <= DW'(1);
            r_q.pd    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CTRL: reg_rdata = {1'b0, sense_done, 1'b0, r_q.mdis, 1'b0, r_q.pd,
                                   5'b0, state, 14'b0, r_q.cmd};
            OFF_ROW:   reg_rdata = DW'(r_q.row);
            OFF_RDAT:  reg_rdata = r_q.rdat;
            OFF_WDAT:  reg_rdata = r_q.wdat;
            OFF_PULSE: reg_rdata = DW'(r_q.pulse);
            OFF_PDIS:  reg_rdata = r_q.pdis;
            OFF_WACC:  reg_rdata = r_q.wacc;
            default: begin
                if (reg_addr[11:8] == SHADOW_PAGE && int'(reg_addr[7:2]) < ROWS)
                    reg_rdata = shw_bits;
            end
        endcase
    end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
    parameter int unsigned ROWS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [4:0]         state,
    input logic               sense_done,
    input logic               pd,
    input logic               mdis,
    input logic [31:0]        wacc,
    input logic [31:0]        pdis,
    input logic [31:0]        rdat,
    input logic               ctrl_wr_req,
    input logic [ROWS*32-1:0] rows_flat
);
    assert_state_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 5'd4 || state == 5'd9 || state == 5'd10 || state == 5'd11));

    assert_rdata_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdat) |-> $past(state) == 5'd9);

    assert_never_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(rows_flat) & ~rows_flat) == '0));

    assert_guard_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wacc != '0 || pdis != '0 || pd) |=> $stable(rows_flat));

    assert_done_after_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_done) |-> $past(state) == 5'd11);

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_req && state != 5'd4) |=> ($stable(pd) && $stable(mdis)));
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.ROWS(ROWS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .sense_done  (sense_done),
    .pd          (r_q.pd),
    .mdis        (r_q.mdis),
    .wacc        (r_q.wacc),
    .pdis        (r_q.pdis),
    .rdat        (r_q.rdat),
    .ctrl_wr_req (reg_wr_en && reg_addr == 12'h000),
    .rows_flat   (rows_flat)
);

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;
    localparam int ROWS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    int unsigned arr[ROWS];
    int unsigned shad[ROWS];
    int unsigned m_rdat = 0, m_wdat = 0, m_pw = 250, m_wacc = 1, m_pdis = 0;
    int m_row = 0, m_cmd = 0, m_state = 4;
    bit m_pd = 1, m_mdis = 0, m_done = 0;

    otp_fuse_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #10 clk = ~clk;

    function automatic int unsigned exp_ctrl();
        return (int'(m_done) << 30) | (int'(m_mdis) << 28) | (int'(m_pd) << 26)
             | (m_state << 16) | m_cmd;
    endfunction

    task automatic check(string req, int unsigned act, int unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output int unsigned v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd_check(string req, logic [11:0] a, int unsigned exp);
        int unsigned v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // issue a command and compare the control word on every cycle until idle
    task automatic run_cmd(string req, int cmd, int lat, bit poke = 0);
        int unsigned v;
        m_cmd = cmd;
        wr(12'h000, (int'(m_mdis) << 28) | (int'(m_pd) << 26) | cmd);
        m_state = (cmd == 1) ? 9 : (cmd == 2) ? 10 : 11;
        if (cmd == 3) m_done = 0;
        for (int k = 0; k < lat; k++) begin
            rd(12'h000, v);
            check(req, v, exp_ctrl());
            if (poke && k == 1) begin
                reg_wr_en = 1'b1; reg_wdata = (32'h1 << 26) | 32'h1;
            end else begin
                reg_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr_en = 1'b0;
        m_state = 4;
        if (cmd == 1) m_rdat = arr[m_row];
        if (cmd == 2 && m_wacc == 0 && m_pdis == 0 && !m_pd) arr[m_row] |= m_wdat;
        if (cmd == 3) begin
            for (int i = 0; i < ROWS; i++) shad[i] = arr[i];
            m_done = 1;
        end
        rd(12'h000, v);
        check(req, v, exp_ctrl());
    endtask

    task automatic set_reg(logic [11:0] a, int unsigned d);
        wr(a, d);
        case (a)
            12'h004: m_row = d % ROWS;
            12'h00C: m_wdat = d;
            12'h01C: m_pw = d & 32'hFFFF;
            12'h02C: m_pdis = d;
            12'h030: m_wacc = d;
            12'h000: begin m_pd = d[26]; m_mdis = d[28]; m_cmd = d & 3; end
            default: ;
        endcase
    endtask

    task automatic prog_row(string req, int row, int unsigned bits);
        set_reg(12'h004, row);
        set_reg(12'h00C, bits);
        run_cmd(req, 2, (m_pw == 0) ? 1 : m_pw);
    endtask

    task automatic read_row(string req, int row);
        set_reg(12'h004, row);
        run_cmd(req, 1, 2);
        rd_check(req, 12'h008, m_rdat);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < ROWS; i++) begin arr[i] = 0; shad[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset register values
        rd_check("R1 ctrl", 12'h000, 32'h0404_0000);
        rd_check("R1 wacc", 12'h030, 1);
        rd_check("R1 pdis", 12'h02C, 0);
        rd_check("R1 pulse", 12'h01C, 250);
        rd_check("R1 rdata", 12'h008, 0);

        set_reg(12'h01C, 3);
        // R5: blocked by write access and power-down (both still at reset)
        prog_row("R5 locked", 5, 32'h0000_00A5);
        read_row("R5 locked", 5);
        check("R5 locked row", m_rdat, 0);

        // open all guards, mirror-disable bit set to see it stored (R7)
        set_reg(12'h000, 32'h1000_0000);
        rd_check("R7 idle ctrl write", 12'h000, exp_ctrl());
        set_reg(12'h030, 0);
        // R3: OR semantics
        prog_row("R3", 5, 32'h0000_00F0);
        read_row("R2 R3", 5);
        check("R3 first", m_rdat, 32'h0000_00F0);
        prog_row("R3", 5, 32'h0000_000F);
        prog_row("R3", 5, 32'h0000_0003);
        read_row("R3", 5);
        check("R3 no clear", m_rdat, 32'h0000_00FF);
        // R4: width zero and longer width
        set_reg(12'h01C, 0);
        prog_row("R4 width0", 15, 32'h8000_0001);
        set_reg(12'h01C, 7);
        prog_row("R4 width7", 2, 32'h1234_0000);
        read_row("R4", 2);
        // R8: row index uses only low address bits
        read_row("R8 wrap", 32'h1F);
        check("R8 wrap", m_rdat, 32'h8000_0001);
        rd_check("R8 addr reg", 12'h004, 15);
        // R5: each guard alone
        set_reg(12'h02C, 1);
        prog_row("R5 pdis", 3, 32'hFFFF_FFFF);
        set_reg(12'h02C, 0);
        set_reg(12'h030, 1);
        prog_row("R5 wacc", 3, 32'hFFFF_FFFF);
        set_reg(12'h030, 0);
        set_reg(12'h000, 32'h1400_0000);
        prog_row("R5 pd", 3, 32'hFFFF_FFFF);
        set_reg(12'h000, 32'h1000_0000);
        read_row("R5", 3);
        check("R5 row3", m_rdat, 0);
        // R7: control write during a program pulse is ignored
        set_reg(12'h01C, 5);
        set_reg(12'h004, 9);
        set_reg(12'h00C, 32'h0F0F_0000);
        run_cmd("R7 busy write", 2, 5, 1);
        read_row("R7", 9);
        check("R7 prog kept", m_rdat, 32'h0F0F_0000);
        // R6: sense by command, shadow window
        rd_check("R6 stale", 12'h114, 0);
        run_cmd("R6 sense cmd", 3, ROWS);
        for (int i = 0; i < ROWS; i++) rd_check("R6 R8 shadow", 12'h100 + 12'(4 * i), shad[i]);
        // R6: shadow stale until sense-start register write
        prog_row("R6", 7, 32'hCAFE_0001);
        rd_check("R6 stale", 12'h11C, 0);
        wr(12'h020, 1);
        m_state = 11; m_done = 0;
        for (int k = 0; k < ROWS; k++) begin
            rd_check("R6 sense reg", 12'h000, exp_ctrl());
            @(negedge clk);
        end
        m_state = 4; m_done = 1;
        for (int i = 0; i < ROWS; i++) shad[i] = arr[i];
        rd_check("R6 done", 12'h000, exp_ctrl());
        rd_check("R6 fresh", 12'h11C, 32'hCAFE_0001);
        rd_check("R6 fresh", 12'h114, 32'h0000_00FF);
        summary();
    end
endmodule